// File: doc/BRIEF.md
# Exception Entry and Return Sequencer

This block sits beside the instruction pipeline and the register file of a 32-bit processor core. Each cycle it looks at seven exception request lines and the live status word. When an unmasked request is present it picks one request by fixed priority. In the next cycle it issues, all in the same cycle, the state writes that enter the handler:
- the return address goes into the link register of the target mode's bank;
- the interrupted status word goes into that mode's saved status register;
- a new status word is written;
- the fetch unit is redirected to the fixed vector address.

The new status word selects the target mode and clears the compressed-instruction state bit. The handler therefore always starts in the native 32-bit instruction set.

On a return strobe the block writes back the status word that the register file presents from the current mode's saved status register. That write restores the mode, the masks and the instruction-set state of the interrupted code, so execution can resume in the compressed state when that state was active. The fast interrupt vector is the highest slot of the table, so its handler can start at the vector without a branch.

Top module: `exc_seq`

## Requirements
- R1: After reset, and in every cycle with no accepted work, the outputs `lr_we`, `sav_we`, `status_we` and `redirect` are all 0.
- R2: One cycle after an accepted request, `lr_we`, `sav_we`, `status_we` and `redirect` are all 1 for exactly that one cycle.
- R3: The link write carries `pc_in + 4`, using the `pc_in` seen in the accepting cycle. `lr_mode` is the target mode, encoded in 5 bits: FIQ 10001, IRQ 10010, reset and software interrupt 10011, both aborts 10111, undefined 11011.
- R4: The saved-status write carries the unmodified `status_in` of the accepting cycle. `sav_mode` equals `lr_mode`.
- R5: The new status word is the old one with three changes: bits [4:0] replaced by the target mode, bit 5 (compressed state) cleared, and the mask bits changed as described in R6. All other bits are kept.
- R6: Entry to IRQ sets bit 7 (IRQ mask). Entry to FIQ or to reset sets bit 7 and bit 6 (FIQ mask). Other entries leave both mask bits unchanged.
- R7: `redirect_addr` is the vector base plus an offset: reset 0x00, undefined 0x04, software interrupt 0x08, prefetch abort 0x0C, data abort 0x10, IRQ 0x18, FIQ 0x1C. The base is 0, or `HIGH_BASE` when `HIGH_VEC` is set.
- R8: The request lines are indexed 0 reset, 1 undefined, 2 software interrupt, 3 prefetch abort, 4 data abort, 5 IRQ, 6 FIQ. Among unmasked requests the winner follows the order reset, data abort, FIQ, IRQ, prefetch abort, undefined, software interrupt.
- R9: A request on line 5 is not taken while `status_in` bit 7 is 1. A request on line 6 is not taken while bit 6 is 1. A lower request then wins instead. Reset is never masked.
- R10: One cycle after `ret_req` with no accepted request, `status_we` is 1 and `status_out` equals `saved_status_in` of the strobing cycle. `lr_we`, `sav_we` and `redirect` stay 0.
- R11: When an accepted request and `ret_req` fall in the same cycle, the entry is performed and the return is dropped: `status_out` is the entry status, not the saved word.
- R12: In the cycle in which `redirect` is 1, no request is accepted. A request held through that cycle is taken again one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| exc_req | input | 7 | Request lines, indexed as in R8 |
| status_in | input | STAT_W | Live status word |
| pc_in | input | ADDR_W | Address of the instruction being interrupted |
| ret_req | input | 1 | Exception return strobe |
| saved_status_in | input | STAT_W | Saved status of the current mode, read from the register file |
| lr_we | output | 1 | Banked link register write strobe |
| lr_mode | output | 5 | Bank selector for the link write |
| lr_data | output | ADDR_W | Return address |
| sav_we | output | 1 | Saved status register write strobe |
| sav_mode | output | 5 | Bank selector for the saved status write |
| sav_data | output | STAT_W | Status word being saved |
| status_we | output | 1 | Status word write strobe |
| status_out | output | STAT_W | New status word |
| redirect | output | 1 | Fetch redirect strobe |
| redirect_addr | output | ADDR_W | Vector fetch address |

## Verification
Two functions of the block can fall in the same cycle: an exception entry and an exception return. Both drive the status write port. The bench provokes the clash directly, by raising `ret_req` together with an unmasked request, and it also provokes it at random, because the return strobe and the request lines are drawn independently. Each result is judged against a bench model in which the entry must win. The status written must be the entry status built from `status_in`, never `saved_status_in`, and all four entry strobes must be present.

// File: rtl/exc_seq_pkg.sv
package exc_seq_pkg;

   localparam int EXC_N = 7;

   typedef enum logic [2:0] {
      EX_RESET = 3'd0,
      EX_UNDEF = 3'd1,
      EX_SWI   = 3'd2,
      EX_PABT  = 3'd3,
      EX_DABT  = 3'd4,
      EX_IRQ   = 3'd5,
      EX_FIQ   = 3'd6
   } exc_kind_e;

   // mode field encodings decoded by the register file banks
   localparam logic [4:0] MODE_FIQ = 5'b10001;
   localparam logic [4:0] MODE_IRQ = 5'b10010;
   localparam logic [4:0] MODE_SVC = 5'b10011;
   localparam logic [4:0] MODE_ABT = 5'b10111;
   localparam logic [4:0] MODE_UND = 5'b11011;

   localparam int POS_T = 5;
   localparam int POS_F = 6;
   localparam int POS_I = 7;

   // index 0 is the highest priority
   localparam exc_kind_e PRIO [EXC_N] =
      '{EX_RESET, EX_DABT, EX_FIQ, EX_IRQ, EX_PABT, EX_UNDEF, EX_SWI};

   function automatic logic [4:0] target_mode(exc_kind_e k);
      case (k)
         EX_FIQ:           return MODE_FIQ;
         EX_IRQ:           return MODE_IRQ;
         EX_PABT, EX_DABT: return MODE_ABT;
         EX_UNDEF:         return MODE_UND;
         default:          return MODE_SVC;
      endcase
   endfunction

   function automatic logic [4:0] vec_offset(exc_kind_e k);
      case (k)
         EX_RESET: return 5'h00;
         EX_UNDEF: return 5'h04;
         EX_SWI:   return 5'h08;
         EX_PABT:  return 5'h0C;
         EX_DABT:  return 5'h10;
         EX_IRQ:   return 5'h18;
         default:  return 5'h1C;
      endcase
   endfunction

endpackage

// File: rtl/exc_prio_arb.sv
module exc_prio_arb
   import exc_seq_pkg::*;
(
   input  logic [EXC_N-1:0] req,
   input  logic             irq_masked,
   input  logic             fiq_masked,
   input  logic             block,
   output logic             hit,
   output exc_kind_e        kind
);

   logic [EXC_N-1:0] eligible;

   always_comb begin
      eligible            = req;
      eligible[EX_IRQ]    = req[EX_IRQ] & ~irq_masked;
      eligible[EX_FIQ]    = req[EX_FIQ] & ~fiq_masked;
      if (block) eligible = '0;
   end

   // walk from lowest to highest priority; the last match wins
   always_comb begin
      hit  = 1'b0;
      kind = EX_RESET;
      for (int i = EXC_N - 1; i >= 0; i--) begin
         if (eligible[PRIO[i]]) begin
            hit  = 1'b1;
            kind = PRIO[i];
         end
      end
   end

endmodule

// File: rtl/exc_status_gen.sv
module exc_status_gen
   import exc_seq_pkg::*;
#(
   parameter int STAT_W = 32
) (
   input  logic [STAT_W-1:0] old_status,
   input  exc_kind_e         kind,
   output logic [STAT_W-1:0] new_status
);

   always_comb begin
      new_status        = old_status;
      new_status[4:0]   = target_mode(kind);
      new_status[POS_T] = 1'b0;
      if (kind == EX_IRQ || kind == EX_FIQ || kind == EX_RESET)
         new_status[POS_I] = 1'b1;
      if (kind == EX_FIQ || kind == EX_RESET)
         new_status[POS_F] = 1'b1;
   end

endmodule

// File: rtl/exc_seq.sv
module exc_seq
   import exc_seq_pkg::*;
#(
   parameter int              ADDR_W    = 32,
   parameter int              STAT_W    = 32,
   parameter int              LINK_OFS  = 4,
   parameter bit              HIGH_VEC  = 1'b0,
   parameter longint unsigned HIGH_BASE = 64'hFFFF_0000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [6:0]        exc_req,
   input  logic [STAT_W-1:0] status_in,
   input  logic [ADDR_W-1:0] pc_in,
   input  logic              ret_req,
   input  logic [STAT_W-1:0] saved_status_in,
   output logic              lr_we,
   output logic [4:0]        lr_mode,
   output logic [ADDR_W-1:0] lr_data,
   output logic              sav_we,
   output logic [4:0]        sav_mode,
   output logic [STAT_W-1:0] sav_data,
   output logic              status_we,
   output logic [STAT_W-1:0] status_out,
   output logic              redirect,
   output logic [ADDR_W-1:0] redirect_addr
);

   localparam logic [ADDR_W-1:0] LINK_INC = ADDR_W'(LINK_OFS);

   if (STAT_W < 8) begin : g_bad_stat
      $error("exc_seq: STAT_W must hold mode, T, F and I fields");
   end
   if (ADDR_W < 8) begin : g_bad_addr
      $error("exc_seq: ADDR_W too small for the vector table");
   end
   if (LINK_OFS < 0) begin : g_bad_link
      $error("exc_seq: LINK_OFS must not be negative");
   end

   logic [ADDR_W-1:0] vec_base;
   if (HIGH_VEC) begin : g_vec_high
      assign vec_base = ADDR_W'(HIGH_BASE);
   end else begin : g_vec_low
      assign vec_base = '0;
   end

   logic              take;
   exc_kind_e         kind;
   logic [STAT_W-1:0] entry_status;

   exc_prio_arb u_arb (
      .req        (exc_req),
      .irq_masked (status_in[POS_I]),
      .fiq_masked (status_in[POS_F]),
      .block      (redirect),
      .hit        (take),
      .kind       (kind)
   );

   exc_status_gen #(.STAT_W(STAT_W)) u_stat (
      .old_status (status_in),
      .kind       (kind),
      .new_status (entry_status)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lr_we         <= 1'b0;
         lr_mode       <= '0;
         lr_data       <= '0;
         sav_we        <= 1'b0;
         sav_mode      <= '0;
         sav_data      <= '0;
         status_we     <= 1'b0;
         status_out    <= '0;
         redirect      <= 1'b0;
         redirect_addr <= '0;
      end else begin
         lr_we     <= 1'b0;
         sav_we    <= 1'b0;
         status_we <= 1'b0;
         redirect  <= 1'b0;
         if (take) begin
            lr_we         <= 1'b1;
            lr_mode       <= target_mode(kind);
            lr_data       <= pc_in + LINK_INC;
            sav_we        <= 1'b1;
            sav_mode      <= target_mode(kind);
            sav_data      <= status_in;
            status_we     <= 1'b1;
            status_out    <= entry_status;
            redirect      <= 1'b1;
            redirect_addr <= vec_base | ADDR_W'(vec_offset(kind));
         end else if (ret_req) begin
            status_we     <= 1'b1;
            status_out    <= saved_status_in;
         end
      end
   end

endmodule

// File: rtl/exc_seq_chk.sv
module exc_seq_chk #(
   parameter int ADDR_W   = 32,
   parameter int STAT_W   = 32,
   parameter int LINK_OFS = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic [STAT_W-1:0] status_in,
   input logic [ADDR_W-1:0] pc_in,
   input logic [STAT_W-1:0] saved_status_in,
   input logic              lr_we,
   input logic [ADDR_W-1:0] lr_data,
   input logic              sav_we,
   input logic [STAT_W-1:0] sav_data,
   input logic              status_we,
   input logic [STAT_W-1:0] status_out,
   input logic              redirect,
   input logic [ADDR_W-1:0] redirect_addr
);

   AST_ENTRY_GROUP: assert property (@(posedge clk) disable iff (!rst_n)
      redirect |-> (lr_we && sav_we && status_we)); // R2

   AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      redirect |=> !redirect); // R12

   AST_LINK_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
      lr_we |-> (lr_data == $past(pc_in) + ADDR_W'(LINK_OFS))); // R3

   AST_SAVED_OLD: assert property (@(posedge clk) disable iff (!rst_n)
      sav_we |-> (sav_data == $past(status_in))); // R4

   AST_NATIVE_STATE: assert property (@(posedge clk) disable iff (!rst_n)
      redirect |-> !status_out[5]); // R5

   AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      (redirect && redirect_addr[4:0] == 5'h18) |-> (!$past(status_in[7]) && status_out[7])); // R9

   AST_RETURN_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      (status_we && !redirect) |-> (!lr_we && !sav_we && status_out == $past(saved_status_in))); // R10

endmodule

bind exc_seq exc_seq_chk #(
   .ADDR_W   (ADDR_W),
   .STAT_W   (STAT_W),
   .LINK_OFS (LINK_OFS)
) u_chk (.*);

// File: tb/tb_exc_seq.sv
module tb_exc_seq;

   localparam int AW = 32;
   localparam int SW = 32;

   logic          clk = 1'b0;
   logic          rst_n;
   logic [6:0]    exc_req;
   logic [SW-1:0] status_in;
   logic [AW-1:0] pc_in;
   logic          ret_req;
   logic [SW-1:0] saved_status_in;
   logic          lr_we, sav_we, status_we, redirect;
   logic [4:0]    lr_mode, sav_mode;
   logic [AW-1:0] lr_data, redirect_addr;
   logic [SW-1:0] sav_data, status_out;

   int  n_chk  = 0;
   int  n_fail = 0;
   bit  done   = 0;

   always #2 clk = ~clk;

   exc_seq dut (
      .clk(clk), .rst_n(rst_n), .exc_req(exc_req), .status_in(status_in),
      .pc_in(pc_in), .ret_req(ret_req), .saved_status_in(saved_status_in),
      .lr_we(lr_we), .lr_mode(lr_mode), .lr_data(lr_data),
      .sav_we(sav_we), .sav_mode(sav_mode), .sav_data(sav_data),
      .status_we(status_we), .status_out(status_out),
      .redirect(redirect), .redirect_addr(redirect_addr)
   );

   // R8 priority model: highest first
   function automatic int pick(logic [6:0] r, logic [SW-1:0] s);
      int order [7] = '{0, 4, 6, 5, 3, 1, 2};
      for (int i = 0; i < 7; i++) begin
         int k = order[i];
         if (r[k] && !(k == 5 && s[7]) && !(k == 6 && s[6])) return k;
      end
      return -1;
   endfunction

   function automatic logic [4:0] mode_of(int k);
      case (k)
         6: return 5'b10001;
         5: return 5'b10010;
         3, 4: return 5'b10111;
         1: return 5'b11011;
         default: return 5'b10011;
      endcase
   endfunction

   function automatic logic [AW-1:0] vec_of(int k);
      case (k)
         0: return 32'h00; 1: return 32'h04; 2: return 32'h08;
         3: return 32'h0C; 4: return 32'h10; 5: return 32'h18;
         default: return 32'h1C;
      endcase
   endfunction

   function automatic logic [SW-1:0] entry_stat(int k, logic [SW-1:0] s);
      logic [SW-1:0] n = s;
      n[4:0] = mode_of(k);
      n[5]   = 1'b0;
      if (k == 5 || k == 6 || k == 0) n[7] = 1'b1;
      if (k == 6 || k == 0)           n[6] = 1'b1;
      return n;
   endfunction

   // drive one cycle of inputs, then check the registered result
   task automatic step(input logic [6:0] r, input logic [SW-1:0] s,
                       input logic [AW-1:0] pc, input logic rt,
                       input logic [SW-1:0] sv, input bit locked, input string tag);
      int  k;
      bit  bad = 0;
      exc_req = r; status_in = s; pc_in = pc; ret_req = rt; saved_status_in = sv;
      k = locked ? -1 : pick(r, s);
      @(negedge clk);
      n_chk++;
      if (k >= 0) begin
         if (!(lr_we && sav_we && status_we && redirect)) bad = 1;
         if (lr_mode != mode_of(k) || sav_mode != mode_of(k)) bad = 1;
         if (lr_data != pc + 32'd4) bad = 1;
         if (sav_data != s) bad = 1;
         if (status_out != entry_stat(k, s)) bad = 1;
         if (redirect_addr != vec_of(k)) bad = 1;
         if (bad)
            $display("FAIL %s: got we=%b%b%b%b mode=%h lr=%h sav=%h st=%h va=%h exp kind=%0d mode=%h lr=%h sav=%h st=%h va=%h",
                     tag, lr_we, sav_we, status_we, redirect, lr_mode, lr_data, sav_data,
                     status_out, redirect_addr, k, mode_of(k), pc + 32'd4, s,
                     entry_stat(k, s), vec_of(k));
      end else if (rt && !locked) begin
         if (lr_we || sav_we || redirect || !status_we || status_out != sv) bad = 1;
         if (bad)
            $display("FAIL %s: got we=%b%b%b%b st=%h exp we=0010 st=%h",
                     tag, lr_we, sav_we, status_we, redirect, status_out, sv);
      end else begin
         if (lr_we || sav_we || status_we || redirect) bad = 1;
         if (bad)
            $display("FAIL %s: got we=%b%b%b%b exp we=0000",
                     tag, lr_we, sav_we, status_we, redirect);
      end
      if (bad) n_fail++;
   endtask

   task automatic idle(input string tag);
      step(7'd0, 32'h0, 32'h0, 1'b0, 32'h0, 1'b0, tag);
   endtask

   initial begin
      int seed;
      seed = $urandom(32'h5EED_0042);
      rst_n = 1'b0; exc_req = '0; status_in = '0; pc_in = '0;
      ret_req = 1'b0; saved_status_in = '0;
      repeat (3) @(negedge clk);
      // R1: reset state
      n_chk++;
      if (lr_we || sav_we || status_we || redirect) begin
         n_fail++;
         $display("FAIL R1: got we=%b%b%b%b exp 0000", lr_we, sav_we, status_we, redirect);
      end
      rst_n = 1'b1;
      idle("R1 idle");

      // each request alone from compressed state, masks clear: R2 R3 R4 R5 R6 R7
      for (int k = 0; k < 7; k++) begin
         step(7'(1 << k), 32'h0000_0030, 32'h0000_1000 + 32'(k * 16), 1'b0, 32'h0, 1'b0, "R2/R3/R4/R5/R6/R7");
         idle("R1 after entry");
      end
      // masks already set survive undefined entry: R6
      step(7'b0000010, 32'hA000_00D0, 32'h200, 1'b0, 32'h0, 1'b0, "R6 keep masks");
      idle("R1");
      // all requests: reset wins (R8)
      step(7'h7F, 32'h0000_00D0, 32'h300, 1'b0, 32'h0, 1'b0, "R8 all");
      idle("R1");
      // data abort over FIQ (R8)
      step(7'b1010000, 32'h10, 32'h400, 1'b0, 32'h0, 1'b0, "R8 dabt>fiq");
      idle("R1");
      // undefined over software interrupt (R8)
      step(7'b0000110, 32'h10, 32'h404, 1'b0, 32'h0, 1'b0, "R8 und>swi");
      idle("R1");
      // masked IRQ alone: nothing (R9)
      step(7'b0100000, 32'h90, 32'h500, 1'b0, 32'h0, 1'b0, "R9 irq masked");
      idle("R1");
      // masked FIQ, open IRQ: IRQ wins (R9)
      step(7'b1100000, 32'h50, 32'h504, 1'b0, 32'h0, 1'b0, "R9 fiq masked");
      idle("R1");
      // reset ignores masks (R9)
      step(7'b0000001, 32'hD0, 32'h508, 1'b0, 32'h0, 1'b0, "R9 reset unmasked");
      idle("R1");
      // return restores compressed state (R10)
      step(7'd0, 32'h12, 32'h600, 1'b1, 32'h0000_0030, 1'b0, "R10 return");
      idle("R1");
      // return with masked IRQ only: return proceeds (R10)
      step(7'b0100000, 32'h92, 32'h604, 1'b1, 32'hF000_0010, 1'b0, "R10 masked req");
      idle("R1");
      // entry and return in one cycle (R11)
      step(7'b0100000, 32'h30, 32'h700, 1'b1, 32'hFFFF_FFFF, 1'b0, "R11 clash");
      idle("R1");
      // held request: taken, blocked, taken again (R12)
      step(7'b0100000, 32'h10, 32'h800, 1'b0, 32'h0, 1'b0, "R12 first");
      step(7'b0100000, 32'h10, 32'h800, 1'b0, 32'h0, 1'b1, "R12 blocked");
      step(7'b0100000, 32'h10, 32'h800, 1'b0, 32'h0, 1'b0, "R12 again");
      idle("R1");

      // constrained random, each bit of the request lines raised with p=1/4
      for (int n = 0; n < 600; n++) begin
         logic [6:0] r;
         for (int b = 0; b < 7; b++) r[b] = ($urandom % 4) == 0;
         step(r, $urandom, $urandom & 32'hFFFF_FFFC, ($urandom % 3) == 0, $urandom,
              1'b0, "R8/R9/R11 random");
         idle("R1 random idle");
      end

      if (!done) begin
         done = 1;
         $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1;
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: got hung run exp completion");
         $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
         $finish;
      end
   end

endmodule